// File: doc/BRIEF.md
# Tagged Shared Mailbox Channel

This block is one mailbox slot that a producer and a consumer share over a 32-bit register bus. The slot is full or empty according to a flag held inside the stored words. No separate handshake signal carries that state. The producer fills the slot by writing the flag set. The consumer takes the message and then frees the slot by writing zero, which also wipes the payload.

A parameter selects one of two layouts.

- **Narrow layout:** one register carries a 31-bit payload, with the full flag in its top bit.
- **Wide layout:** four data words carry the payload, and a separate tag word holds the full flag in its top bit. The producer writes the data words first and the tag last. The consumer zeroes the data words, then the tag.

The block exports the raw full and empty levels to an interrupt aggregator. It also exports two local interrupts, each gated by its own enable bit. The empty interrupt is a level: it stays asserted for as long as the slot is idle and its enable is set.

Top module: `mbx_channel`

## Requirements
- R1: After reset, every stored word, the tag and both enables read zero, `slot_full` is 0, `slot_empty` is 1, and both interrupts are 0.
- R2: In the narrow layout, a bus write to offset 0x00 stores the whole 32-bit word, and reading 0x00 returns it. From the next cycle, `slot_full` equals bit 31 of the written word.
- R3: In the narrow layout, a consumer write of 0x0 to offset 0x00 clears the payload and makes the slot empty from the next cycle.
- R4: In the wide layout, the data words sit at 0x48, 0x4C, 0x50 and 0x54 (word 0 to word 3), and each reads back what was last written to it. Writes to these words never change `slot_full`.
- R5: In the wide layout, the tag sits at 0x40 and reads back its whole written value. From the next cycle, `slot_full` equals bit 31 of the tag.
- R6: The full-interrupt enable is bit 0 at offset 0x04, and the empty-interrupt enable is bit 0 at offset 0x08. Both layouts have them. Only bit 0 is stored, and bits 31..1 read as zero.
- R7: `irq_full` is `slot_full` AND the full enable. `irq_empty` is NOT `slot_full` AND the empty enable.
- R8: `slot_empty` is always the inverse of `slot_full`, and it holds as a level while the slot is idle.
- R9: Writes to any offset not mapped in the active layout change nothing. Reads of such offsets return zero. In the narrow layout 0x40 to 0x54 are unmapped; in the wide layout 0x00 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset used for both the write and the read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data at `bus_addr`, combinational |
| slot_full | output | 1 | Raw full level |
| slot_empty | output | 1 | Raw empty level |
| irq_full | output | 1 | Full interrupt, after the local enable |
| irq_empty | output | 1 | Empty interrupt, after the local enable |

## Verification
One narrow instance and one wide instance receive the same bus traffic. Each is compared on every clock against a behavioural model.

**Directed phase:**
- A full message followed by a zero release separates correct release (R3) from a design that only drops the flag.
- A payload written with bit 31 clear shows that storing a word and marking the slot full are distinct.
- Data-word writes made with the tag still clear show whether fullness leaks from data writes (R4).
- Writes of all ones to the enables expose any stored upper bits (R6).
- Writes to 0x00 on the wide instance and to 0x40 on the narrow one expose decoding that crosses layouts (R9).

**Random phase:** a random mix of mapped and unmapped writes, with bit 31 varied, checks how enables and fullness interact under back-to-back traffic.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Byte offsets inside the channel window.
  localparam int OFS_MAIN     = 'h00;
  localparam int OFS_EN_FULL  = 'h04;
  localparam int OFS_EN_EMPTY = 'h08;
  localparam int OFS_TAG      = 'h40;
  localparam int OFS_DATA0    = 'h48;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MAIN,
    SEL_EN_FULL,
    SEL_EN_EMPTY,
    SEL_TAG,
    SEL_DATA
  } sel_e;

  // Is a byte offset mapped in the selected layout?
  function automatic logic is_mapped(input int ofs, input bit wide, input int nwords);
    logic hit;
    hit = (ofs == OFS_EN_FULL) || (ofs == OFS_EN_EMPTY);
    if (!wide) begin
      hit = hit || (ofs == OFS_MAIN);
    end else begin
      hit = hit || (ofs == OFS_TAG);
      for (int k = 0; k < nwords; k++) begin
        if (ofs == OFS_DATA0 + 4 * k) hit = 1'b1;
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W = 8,
  parameter bit WIDE   = 1'b0,
  parameter int NWORDS = 4,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::sel_e     sel,
  output logic [IDX_W-1:0]  idx
);
  import mbx_pkg::*;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr == ADDR_W'(OFS_EN_FULL)) begin
      sel = SEL_EN_FULL;
    end else if (addr == ADDR_W'(OFS_EN_EMPTY)) begin
      sel = SEL_EN_EMPTY;
    end else if (!WIDE && addr == ADDR_W'(OFS_MAIN)) begin
      sel = SEL_MAIN;
    end else if (WIDE && addr == ADDR_W'(OFS_TAG)) begin
      sel = SEL_TAG;
    end else if (WIDE) begin
      for (int k = 0; k < NWORDS; k++) begin
        if (addr == ADDR_W'(OFS_DATA0 + 4 * k)) begin
          sel = SEL_DATA;
          idx = IDX_W'(k);
        end
      end
    end
  end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter bit WIDE   = 1'b0,
  parameter int NWORDS = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int FLAG  = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  mbx_pkg::sel_e     sel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              slot_full,
  output logic [DATA_W-1:0] rd_main,
  output logic [DATA_W-1:0] rd_tag,
  output logic [DATA_W-1:0] rd_data [NWORDS]
);
  import mbx_pkg::*;

  generate
    if (!WIDE) begin : g_narrow
      logic [DATA_W-1:0] main_q, main_d;
      logic              main_ce;

      always_comb begin
        main_ce = wr_en && (sel == SEL_MAIN);
        main_d  = main_ce ? wdata : main_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       main_q <= '0;
        else if (main_ce) main_q <= main_d;
      end

      assign rd_main   = main_q;
      assign rd_tag    = '0;
      assign slot_full = main_q[FLAG];
      for (genvar k = 0; k < NWORDS; k++) begin : g_zero
        assign rd_data[k] = '0;
      end
    end else begin : g_wide
      logic [DATA_W-1:0] tag_q, tag_d;
      logic              tag_ce;

      always_comb begin
        tag_ce = wr_en && (sel == SEL_TAG);
        tag_d  = tag_ce ? wdata : tag_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tag_q <= '0;
        else if (tag_ce) tag_q <= tag_d;
      end

      for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [DATA_W-1:0] word_q, word_d;
        logic              word_ce;

        always_comb begin
          word_ce = wr_en && (sel == SEL_DATA) && (idx == IDX_W'(k));
          word_d  = word_ce ? wdata : word_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       word_q <= '0;
          else if (word_ce) word_q <= word_d;
        end

        assign rd_data[k] = word_q;
      end

      assign rd_main   = '0;
      assign rd_tag    = tag_q;
      assign slot_full = tag_q[FLAG];
    end
  endgenerate

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  mbx_pkg::sel_e sel,
  input  logic          wbit,
  input  logic          slot_full,
  output logic          en_full,
  output logic          en_empty,
  output logic          irq_full,
  output logic          irq_empty
);
  import mbx_pkg::*;

  logic en_full_d, en_empty_d;
  logic full_ce, empty_ce;

  always_comb begin
    full_ce    = wr_en && (sel == SEL_EN_FULL);
    empty_ce   = wr_en && (sel == SEL_EN_EMPTY);
    en_full_d  = full_ce  ? wbit : en_full;
    en_empty_d = empty_ce ? wbit : en_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_full  <= 1'b0;
      en_empty <= 1'b0;
    end else begin
      if (full_ce)  en_full  <= en_full_d;
      if (empty_ce) en_empty <= en_empty_d;
    end
  end

  assign irq_full  = slot_full & en_full;
  assign irq_empty = ~slot_full & en_empty;

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter bit WIDE   = 1'b0,
  parameter int NWORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              slot_full,
  output logic              slot_empty,
  output logic              irq_full,
  output logic              irq_empty
);
  import mbx_pkg::*;

  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_main, rd_tag;
  logic [DATA_W-1:0] rd_data [NWORDS];
  logic              en_full, en_empty;

  mbx_decode #(.ADDR_W(ADDR_W), .WIDE(WIDE), .NWORDS(NWORDS)) u_decode (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (idx)
  );

  mbx_store #(.WIDE(WIDE), .NWORDS(NWORDS), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we),
    .sel       (sel),
    .idx       (idx),
    .wdata     (bus_wdata),
    .slot_full (slot_full),
    .rd_main   (rd_main),
    .rd_tag    (rd_tag),
    .rd_data   (rd_data)
  );

  mbx_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we),
    .sel       (sel),
    .wbit      (bus_wdata[0]),
    .slot_full (slot_full),
    .en_full   (en_full),
    .en_empty  (en_empty),
    .irq_full  (irq_full),
    .irq_empty (irq_empty)
  );

  assign slot_empty = ~slot_full;

  always_comb begin
    unique case (sel)
      SEL_MAIN:     bus_rdata = rd_main;
      SEL_EN_FULL:  bus_rdata = {{(DATA_W-1){1'b0}}, en_full};
      SEL_EN_EMPTY: bus_rdata = {{(DATA_W-1){1'b0}}, en_empty};
      SEL_TAG:      bus_rdata = rd_tag;
      SEL_DATA:     bus_rdata = rd_data[idx];
      default:      bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbx_channel_chk.sv
module mbx_channel_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter bit WIDE   = 1'b0,
  parameter int NWORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              slot_full,
  input logic              slot_empty,
  input logic              irq_full,
  input logic              irq_empty
);
  import mbx_pkg::*;

  logic wr_main, wr_tag, wr_data, wr_en_full, wr_unmapped;

  always_comb begin
    wr_main     = bus_we && (bus_addr == ADDR_W'(OFS_MAIN));
    wr_tag      = bus_we && (bus_addr == ADDR_W'(OFS_TAG));
    wr_en_full  = bus_we && (bus_addr == ADDR_W'(OFS_EN_FULL));
    wr_data     = 1'b0;
    for (int k = 0; k < NWORDS; k++) begin
      if (bus_we && bus_addr == ADDR_W'(OFS_DATA0 + 4 * k)) wr_data = 1'b1;
    end
    wr_unmapped = bus_we && !is_mapped(int'(bus_addr), WIDE, NWORDS);
  end

  p_empty_inverse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_empty == !slot_full);

  p_irq_full_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> slot_full);

  p_irq_empty_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> !slot_full);

  p_enable_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_full && bus_wdata[0] && slot_full) |=> irq_full);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(slot_full));

  generate
    if (!WIDE) begin : g_narrow
      p_main_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_main |=> (slot_full == $past(bus_wdata[DATA_W-1])));

      p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_main && bus_wdata == '0) |=> slot_empty);
    end else begin : g_wide
      p_tag_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tag |=> (slot_full == $past(bus_wdata[DATA_W-1])));

      p_data_keeps_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> $stable(slot_full));
    end
  endgenerate

endmodule

bind mbx_channel mbx_channel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WIDE   (WIDE),
  .NWORDS (NWORDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .slot_full  (slot_full),
  .slot_empty (slot_empty),
  .irq_full   (irq_full),
  .irq_empty  (irq_empty)
);

// File: tb/mbx_channel_tb.sv
`timescale 1ns/1ps
module mbx_channel_tb;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;

  logic [31:0] n_rdata, w_rdata;
  logic        n_full, n_empty, n_irqf, n_irqe;
  logic        w_full, w_empty, w_irqf, w_irqe;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  mbx_channel #(.WIDE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(n_rdata), .slot_full(n_full),
    .slot_empty(n_empty), .irq_full(n_irqf), .irq_empty(n_irqe)
  );

  mbx_channel #(.WIDE(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(w_rdata), .slot_full(w_full),
    .slot_empty(w_empty), .irq_full(w_irqf), .irq_empty(w_irqe)
  );

  // Behavioural reference model
  logic [31:0] mn_word;
  logic        mn_ef, mn_ee;
  logic [31:0] mw_tag;
  logic [31:0] mw_d [4];
  logic        mw_ef, mw_ee;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mn_word <= 0; mn_ef <= 0; mn_ee <= 0;
      mw_tag  <= 0; mw_ef <= 0; mw_ee <= 0;
      for (int k = 0; k < 4; k++) mw_d[k] <= 0;
    end else if (bus_we) begin
      case (bus_addr)
        8'h00: mn_word <= bus_wdata;
        8'h04: begin mn_ef <= bus_wdata[0]; mw_ef <= bus_wdata[0]; end
        8'h08: begin mn_ee <= bus_wdata[0]; mw_ee <= bus_wdata[0]; end
        8'h40: mw_tag  <= bus_wdata;
        8'h48: mw_d[0] <= bus_wdata;
        8'h4C: mw_d[1] <= bus_wdata;
        8'h50: mw_d[2] <= bus_wdata;
        8'h54: mw_d[3] <= bus_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_rd(input bit wide, input logic [7:0] a);
    case (a)
      8'h00: return wide ? 32'h0 : mn_word;
      8'h04: return {31'h0, wide ? mw_ef : mn_ef};
      8'h08: return {31'h0, wide ? mw_ee : mn_ee};
      8'h40: return wide ? mw_tag : 32'h0;
      8'h48: return wide ? mw_d[0] : 32'h0;
      8'h4C: return wide ? mw_d[1] : 32'h0;
      8'h50: return wide ? mw_d[2] : 32'h0;
      8'h54: return wide ? mw_d[3] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input bit wide, input logic [7:0] a);
    if (a == 8'h04 || a == 8'h08) return "R6";
    if (!wide && a == 8'h00) return "R2";
    if (wide && a == 8'h40) return "R5";
    if (wide && (a == 8'h48 || a == 8'h4C || a == 8'h50 || a == 8'h54)) return "R4";
    return "R9";
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, got, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp(rd_tag(1'b0, bus_addr), "narrow rdata", n_rdata, exp_rd(1'b0, bus_addr));
      cmp(rd_tag(1'b1, bus_addr), "wide rdata",   w_rdata, exp_rd(1'b1, bus_addr));
      cmp("R2", "narrow full",  {31'h0, n_full},  {31'h0, mn_word[31]});
      cmp("R5", "wide full",    {31'h0, w_full},  {31'h0, mw_tag[31]});
      cmp("R8", "narrow empty", {31'h0, n_empty}, {31'h0, ~mn_word[31]});
      cmp("R8", "wide empty",   {31'h0, w_empty}, {31'h0, ~mw_tag[31]});
      cmp("R7", "narrow irq_full",  {31'h0, n_irqf}, {31'h0, mn_word[31] & mn_ef});
      cmp("R7", "narrow irq_empty", {31'h0, n_irqe}, {31'h0, ~mn_word[31] & mn_ee});
      cmp("R7", "wide irq_full",    {31'h0, w_irqf}, {31'h0, mw_tag[31] & mw_ef});
      cmp("R7", "wide irq_empty",   {31'h0, w_irqe}, {31'h0, ~mw_tag[31] & mw_ee});
    end
  end

  // Called just after a rising edge; returns just after the next one
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] en,
                        input logic [31:0] ew, input string tag);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    cmp(tag, "directed narrow read", n_rdata, en);
    cmp(tag, "directed wide read",   w_rdata, ew);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cmp("R1", "narrow full",  {31'h0, n_full},  32'h0);
    cmp("R1", "wide empty",   {31'h0, w_empty}, 32'h1);
    cmp("R1", "narrow irqs",  {30'h0, n_irqf, n_irqe}, 32'h0);
    cmp("R1", "wide irqs",    {30'h0, w_irqf, w_irqe}, 32'h0);
    cmp("R1", "narrow word",  n_rdata, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd_chk(8'h48, 32'h0, 32'h0, "R1");

    // R6: only bit 0 of the enables is kept
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h1, 32'h1, "R6");

    // R2: narrow producer message; wide layout ignores 0x00 (R9)
    wr(8'h00, 32'h8000_1234);
    rd_chk(8'h00, 32'h8000_1234, 32'h0, "R2");
    cmp("R7", "narrow irq_full after message", {31'h0, n_irqf}, 32'h1);

    // R3: consumer releases with zero
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0, 32'h0, "R3");
    cmp("R3", "narrow empty after release", {31'h0, n_empty}, 32'h1);

    // R8 / R7: empty stays asserted while idle
    wr(8'h08, 32'h1);
    repeat (3) rd_chk(8'h08, 32'h1, 32'h1, "R8");
    cmp("R7", "wide irq_empty idle", {31'h0, w_irqe}, 32'h1);

    // R4: data words load without touching fullness
    wr(8'h48, 32'h1111_1111);
    wr(8'h4C, 32'h2222_2222);
    wr(8'h50, 32'h3333_3333);
    wr(8'h54, 32'h4444_4444);
    rd_chk(8'h50, 32'h0, 32'h3333_3333, "R4");
    cmp("R4", "wide full after data", {31'h0, w_full}, 32'h0);

    // R5: tag marks full; R9: narrow ignores tag offset
    wr(8'h40, 32'h8000_0000);
    rd_chk(8'h40, 32'h0, 32'h8000_0000, "R5");
    cmp("R5", "wide full after tag", {31'h0, w_full}, 32'h1);
    cmp("R9", "narrow full after tag write", {31'h0, n_full}, 32'h0);

    // Wide consumer release: data first, tag last
    wr(8'h48, 32'h0); wr(8'h4C, 32'h0); wr(8'h50, 32'h0); wr(8'h54, 32'h0);
    cmp("R4", "wide full during data clear", {31'h0, w_full}, 32'h1);
    wr(8'h40, 32'h0);
    rd_chk(8'h54, 32'h0, 32'h0, "R5");
    cmp("R5", "wide empty after tag clear", {31'h0, w_empty}, 32'h1);

    // R9: unmapped offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    rd_chk(8'h44, 32'h0, 32'h0, "R9");
    rd_chk(8'h0C, 32'h0, 32'h0, "R9");

    // R2: payload without the flag is stored but leaves the slot empty
    wr(8'h00, 32'h0000_00AB);
    rd_chk(8'h00, 32'h0000_00AB, 32'h0, "R2");
    cmp("R2", "narrow full with flag clear", {31'h0, n_full}, 32'h0);

    // Random traffic, model compared every cycle
    for (int i = 0; i < 400; i++) begin
      logic [7:0] pick;
      case ($urandom_range(0, 9))
        0: pick = 8'h00; 1: pick = 8'h04; 2: pick = 8'h08; 3: pick = 8'h40;
        4: pick = 8'h44; 5: pick = 8'h48; 6: pick = 8'h4C; 7: pick = 8'h50;
        8: pick = 8'h54; default: pick = 8'h0C;
      endcase
      bus_we    = ($urandom_range(0, 2) != 0);
      bus_addr  = pick;
      bus_wdata = $urandom();
      if ($urandom_range(0, 3) == 0) bus_wdata = 32'h0;
      @(posedge clk); #1;
    end
    bus_we = 1'b0;
    @(posedge clk); #1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule